// File: doc/BRIEF.md
# Isolated Comparator Output Supervisor

This block decides what the two outputs of a comparator with separate low-side and high-side supplies show while those supplies come up, go down or fail. It watches a low-side supply-good flag, a high-side supply-good flag, a high-side link-alive indication and the raw comparator decision. It drives an open-drain output, modelled as a Hi-Z flag plus a drive-low enable, and a push-pull output that always carries the inverse sense of the open-drain line.

Four cycle counters, each sized by a parameter, stand in for the analog timing. The first is the low-side start-up time. The second and third are the high-side start-up time and the high-side blanking time, which are counted back to back. The fourth is the fault-detection delay. The fault delay is shorter than the blanking window, so a high side that is still settling is reported as faulty before normal operation begins. Losing the low supply always forces a separate unpowered state that is distinct from the fault state. A short drop of the high side only freezes the outputs. A long drop raises the fault, and the high side must then go through its whole start-up and blanking window again.

Top module: `cmp_out_supervisor`

## Requirements
- R1: Whenever `lo_good` is 0, in that same cycle and whatever the high-side inputs are, `od_hiz`=1, `od_pull_low`=0 and `pp_out`=0 (the unpowered state).
- R2: After `lo_good` rises, the outputs stay in the Hi-Z state (`od_hiz`=1, `od_pull_low`=0, `pp_out`=0) for exactly `LS_CYCLES` rising clock edges. They can leave that state no earlier than the `LS_CYCLES`-th edge.
- R3: If the high side is not ready, the fault state (`od_hiz`=0, `od_pull_low`=1, `pp_out`=1) appears at the edge numbered `LS_CYCLES`+`FLT_CYCLES` after `lo_good` rises.
- R4: `pp_out` always equals `od_pull_low`. While `od_hiz` is 1, both of them are 0.
- R5: The high side becomes ready after `HS_START_CYCLES`+`HS_BLANK_CYCLES` consecutive edges on which `hi_good` and `hi_link` are both 1. Normal operation starts on that edge, and any fault shown is cleared on it.
- R6: In normal operation, `cmp_raw`=1 gives `od_hiz`=0, `od_pull_low`=0, `pp_out`=0. `cmp_raw`=0 gives `od_hiz`=0, `od_pull_low`=1, `pp_out`=1. The outputs follow `cmp_raw` in the same cycle.
- R7: If the high side is already ready when `lo_good` rises, normal operation starts at the `LS_CYCLES`-th edge and no fault is ever shown.
- R8: In normal operation, the high side counts as missing when `hi_good` or `hi_link` is 0. If it is missing for fewer than `FLT_CYCLES` consecutive edges, the outputs hold their last value and `cmp_raw` is ignored. On the `FLT_CYCLES`-th consecutive missing edge, the fault state appears.
- R9: Once a fault has been declared, leaving it needs a fresh, uninterrupted run of `HS_START_CYCLES`+`HS_BLANK_CYCLES` good edges. A missing edge during that run restarts the count from zero.
- R10: If the high side becomes ready on the same edge on which the fault delay would expire, readiness wins: normal operation starts and no fault is shown.
- R11: The configuration keeps `FLT_CYCLES` strictly smaller than `HS_BLANK_CYCLES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lo_good | input | 1 | Low-side supply is above its undervoltage level |
| hi_good | input | 1 | High-side supply is above its undervoltage level |
| hi_link | input | 1 | High side is communicating across the barrier |
| cmp_raw | input | 1 | Raw comparator decision |
| od_pull_low | output | 1 | Open-drain output drives low |
| od_hiz | output | 1 | Open-drain output is high impedance (unpowered/start-up) |
| pp_out | output | 1 | Push-pull output, inverse sense of the open-drain line |

## Verification
Two functions can fall on the same clock edge: the high-side readiness timer can expire in the same cycle in which the fault-delay counter reaches its limit. The bench provokes this by raising the high side a fixed number of edges before the low side. The lead is chosen so that the blanking window ends exactly at edge `LS_CYCLES`+`FLT_CYCLES`. The outputs are then judged one edge before that point, where they must still be Hi-Z, and on that edge, where they must show normal operation and never the fault state. A second pairing is a short high-side drop that overlaps a change of `cmp_raw`. There the held output must win over the live comparator value.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_WAIT  = 2'd1,
        MODE_FAULT = 2'd2,
        MODE_RUN   = 2'd3
    } sup_mode_e;

    typedef struct packed {
        logic hiz;
        logic low;
    } od_drive_t;

endpackage

// File: rtl/sup_ls_timer.sv
module sup_ls_timer #(
    parameter int unsigned LS_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lo_good,
    output logic ls_ready
);
    localparam int unsigned CW = $clog2(LS_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ready;
    } ls_state_t;

    ls_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!lo_good) begin
            st_d.cnt   = '0;
            st_d.ready = 1'b0;
        end else if (!st_q.ready) begin
            if (st_q.cnt == CW'(LS_CYCLES - 1)) begin
                st_d.cnt   = '0;
                st_d.ready = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ls_ready = st_q.ready;

endmodule

// File: rtl/sup_hs_tracker.sv
module sup_hs_tracker #(
    parameter int unsigned HS_START_CYCLES = 8,
    parameter int unsigned HS_BLANK_CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_alive,
    input  logic fault_set,
    output logic hs_ready,
    output logic hs_ready_set
);
    localparam int unsigned TOTAL = HS_START_CYCLES + HS_BLANK_CYCLES;
    localparam int unsigned CW    = $clog2(TOTAL + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ready;
    } hs_state_t;

    hs_state_t st_d, st_q;
    logic      set_d;

    always_comb begin
        st_d  = st_q;
        set_d = hs_alive && !st_q.ready && (st_q.cnt == CW'(TOTAL - 1));
        if (!hs_alive) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CW'(TOTAL)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (set_d) begin
            st_d.ready = 1'b1;
        end else if (fault_set) begin
            st_d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hs_ready     = st_q.ready;
    assign hs_ready_set = set_d;

endmodule

// File: rtl/sup_fault_timer.sv
module sup_fault_timer #(
    parameter int unsigned FLT_CYCLES = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lo_good,
    input  logic ls_ready,
    input  logic hs_ready,
    input  logic hs_alive,
    input  logic hs_ready_set,
    output logic fault,
    output logic fault_set
);
    localparam int unsigned CW = $clog2(FLT_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fault;
    } flt_state_t;

    flt_state_t st_d, st_q;
    logic       counting;
    logic       set_d;

    always_comb begin
        st_d     = st_q;
        set_d    = 1'b0;
        counting = lo_good && ls_ready && !st_q.fault && (!hs_ready || !hs_alive);
        if (!counting) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CW'(FLT_CYCLES - 1)) begin
            st_d.cnt = '0;
            set_d    = !hs_ready_set;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (!lo_good || hs_ready_set) begin
            st_d.fault = 1'b0;
        end else if (set_d) begin
            st_d.fault = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault     = st_q.fault;
    assign fault_set = set_d;

endmodule

// File: rtl/cmp_out_supervisor.sv
module cmp_out_supervisor #(
    parameter int unsigned LS_CYCLES       = 20,
    parameter int unsigned HS_START_CYCLES = 8,
    parameter int unsigned HS_BLANK_CYCLES = 50,
    parameter int unsigned FLT_CYCLES      = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lo_good,
    input  logic hi_good,
    input  logic hi_link,
    input  logic cmp_raw,
    output logic od_pull_low,
    output logic od_hiz,
    output logic pp_out
);
    import sup_pkg::*;

    logic             hs_alive;
    logic             ls_ready;
    logic             hs_ready;
    logic             hs_ready_set;
    logic             fault;
    logic             fault_set;
    logic             hold_d, hold_q;
    sup_mode_e        mode;
    od_drive_t        drv;

    assign hs_alive = hi_good && hi_link;

    sup_ls_timer #(
        .LS_CYCLES(LS_CYCLES)
    ) u_ls (
        .clk      (clk),
        .rst_n    (rst_n),
        .lo_good  (lo_good),
        .ls_ready (ls_ready)
    );

    sup_hs_tracker #(
        .HS_START_CYCLES(HS_START_CYCLES),
        .HS_BLANK_CYCLES(HS_BLANK_CYCLES)
    ) u_hs (
        .clk          (clk),
        .rst_n        (rst_n),
        .hs_alive     (hs_alive),
        .fault_set    (fault_set),
        .hs_ready     (hs_ready),
        .hs_ready_set (hs_ready_set)
    );

    sup_fault_timer #(
        .FLT_CYCLES(FLT_CYCLES)
    ) u_flt (
        .clk          (clk),
        .rst_n        (rst_n),
        .lo_good      (lo_good),
        .ls_ready     (ls_ready),
        .hs_ready     (hs_ready),
        .hs_alive     (hs_alive),
        .hs_ready_set (hs_ready_set),
        .fault        (fault),
        .fault_set    (fault_set)
    );

    always_comb begin
        if (!lo_good) begin
            mode = MODE_OFF;
        end else if (!ls_ready) begin
            mode = MODE_WAIT;
        end else if (fault) begin
            mode = MODE_FAULT;
        end else if (hs_ready) begin
            mode = MODE_RUN;
        end else begin
            mode = MODE_WAIT;
        end
    end

    always_comb begin
        hold_d = hold_q;
        unique case (mode)
            MODE_OFF, MODE_WAIT: begin
                drv.hiz = 1'b1;
                drv.low = 1'b0;
            end
            MODE_FAULT: begin
                drv.hiz = 1'b0;
                drv.low = 1'b1;
            end
            MODE_RUN: begin
                drv.hiz = 1'b0;
                if (hs_alive) begin
                    drv.low = !cmp_raw;
                    hold_d  = !cmp_raw;
                end else begin
                    drv.low = hold_q;
                end
            end
            default: begin
                drv.hiz = 1'b1;
                drv.low = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign od_hiz      = drv.hiz;
    assign od_pull_low = drv.low;
    assign pp_out      = drv.low;

endmodule

// File: rtl/sup_checker.sv
module sup_checker #(
    parameter int unsigned LS_CYCLES  = 20,
    parameter int unsigned FLT_CYCLES = 30
) (
    input logic clk,
    input logic rst_n,
    input logic lo_good,
    input logic hi_good,
    input logic hi_link,
    input logic od_pull_low,
    input logic od_hiz,
    input logic pp_out
);
    localparam int unsigned LW = $clog2(LS_CYCLES + 1);
    localparam int unsigned MW = $clog2(FLT_CYCLES + 1);

    logic [LW-1:0] lo_cnt_q;
    logic [MW-1:0] miss_cnt_q;
    logic          seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt_q   <= '0;
            miss_cnt_q <= '0;
            seen_q     <= 1'b0;
        end else begin
            seen_q <= 1'b1;
            if (!lo_good) begin
                lo_cnt_q <= '0;
            end else if (lo_cnt_q != LW'(LS_CYCLES)) begin
                lo_cnt_q <= lo_cnt_q + 1'b1;
            end
            if (hi_good && hi_link) begin
                miss_cnt_q <= '0;
            end else if (miss_cnt_q != MW'(FLT_CYCLES)) begin
                miss_cnt_q <= miss_cnt_q + 1'b1;
            end
        end
    end

    a_r1_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_good |-> (od_hiz && !od_pull_low && !pp_out));

    a_r2_startup_window: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_good && (lo_cnt_q < LW'(LS_CYCLES))) |-> od_hiz);

    a_r4_hiz_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        od_hiz |-> (!pp_out && !od_pull_low));

    a_r8_short_miss_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && lo_good && $past(lo_good) && !od_hiz && $past(!od_hiz)
         && !(hi_good && hi_link) && (miss_cnt_q < MW'(FLT_CYCLES)))
        |-> $stable(od_pull_low));

endmodule

bind cmp_out_supervisor sup_checker #(
    .LS_CYCLES  (LS_CYCLES),
    .FLT_CYCLES (FLT_CYCLES)
) u_sup_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .lo_good     (lo_good),
    .hi_good     (hi_good),
    .hi_link     (hi_link),
    .od_pull_low (od_pull_low),
    .od_hiz      (od_hiz),
    .pp_out      (pp_out)
);

// File: tb/cmp_out_supervisor_test.sv
module cmp_out_supervisor_test;

    localparam int CLK_PERIOD = 10;
    localparam int LS  = 20;
    localparam int HSS = 8;
    localparam int HSB = 50;
    localparam int FLT = 30;
    localparam int HST = HSS + HSB;

    localparam logic [2:0] EXP_OFF   = 3'b100;
    localparam logic [2:0] EXP_FAULT = 3'b011;
    localparam logic [2:0] EXP_RUN1  = 3'b000;
    localparam logic [2:0] EXP_RUN0  = 3'b011;

    logic clk = 1'b0;
    logic rst_n, lo_good, hi_good, hi_link, cmp_raw;
    logic od_pull_low, od_hiz, pp_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    cmp_out_supervisor #(
        .LS_CYCLES(LS), .HS_START_CYCLES(HSS),
        .HS_BLANK_CYCLES(HSB), .FLT_CYCLES(FLT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .lo_good(lo_good), .hi_good(hi_good),
        .hi_link(hi_link), .cmp_raw(cmp_raw), .od_pull_low(od_pull_low),
        .od_hiz(od_hiz), .pp_out(pp_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [2:0] exp);
        logic [2:0] got;
        got = {od_hiz, od_pull_low, pp_out};
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: {hiz,low,pp} got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; lo_good = 1'b0; hi_good = 1'b0; hi_link = 1'b0; cmp_raw = 1'b1;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic bring_up();
        do_reset();
        hi_good = 1'b1; hi_link = 1'b1;
        step(HST);
        lo_good = 1'b1;
        step(LS);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset unpowered", EXP_OFF);
    endtask

    task automatic t_hs_absent();
        do_reset();
        lo_good = 1'b1;
        step(LS - 1);
        chk("R2 start-up hold", EXP_OFF);
        step(FLT);
        chk("R3 one edge before fault", EXP_OFF);
        step(1);
        chk("R3 R4 no-power fault", EXP_FAULT);
        lo_good = 1'b0;
        #1;
        chk("R1 low supply lost from fault", EXP_OFF);
    endtask

    task automatic t_late_high();
        do_reset();
        lo_good = 1'b1;
        step(5);
        hi_good = 1'b1; hi_link = 1'b1;
        step(45);
        chk("R3 fault before blanking ends", EXP_FAULT);
        step(12);
        chk("R5 still blanking", EXP_FAULT);
        step(1);
        chk("R5 normal after blanking", EXP_RUN1);
        cmp_raw = 1'b0;
        #1;
        chk("R6 cmp 0", EXP_RUN0);
        cmp_raw = 1'b1;
        #1;
        chk("R6 cmp 1", EXP_RUN1);
    endtask

    task automatic t_high_first();
        do_reset();
        hi_good = 1'b1; hi_link = 1'b1;
        step(HST);
        lo_good = 1'b1;
        step(LS - 1);
        chk("R7 hold before low start-up done", EXP_OFF);
        step(1);
        chk("R7 normal at low start-up", EXP_RUN1);
        step(FLT + 5);
        chk("R7 no fault later", EXP_RUN1);
    endtask

    task automatic t_glitch_and_recover();
        bring_up();
        cmp_raw = 1'b1;
        hi_good = 1'b0;
        cmp_raw = 1'b0;
        step(FLT - 1);
        chk("R8 short drop holds, cmp ignored", EXP_RUN1);
        hi_good = 1'b1;
        #1;
        chk("R8 resume follows cmp", EXP_RUN0);
        cmp_raw = 1'b1;
        step(FLT + 2);
        chk("R8 no fault after short drop", EXP_RUN1);
        hi_link = 1'b0;
        step(FLT - 1);
        chk("R8 link drop one edge short", EXP_RUN1);
        step(1);
        chk("R8 long link drop faults", EXP_FAULT);
        hi_link = 1'b1;
        step(20);
        hi_link = 1'b0;
        step(1);
        hi_link = 1'b1;
        step(HST - 1);
        chk("R9 interrupted recovery restarts", EXP_FAULT);
        step(1);
        chk("R9 recovered after full window", EXP_RUN1);
    endtask

    task automatic t_collision();
        do_reset();
        hi_good = 1'b1; hi_link = 1'b1;
        step(HST - LS - FLT);
        lo_good = 1'b1;
        step(LS + FLT - 1);
        chk("R10 edge before tie", EXP_OFF);
        step(1);
        chk("R10 readiness wins tie", EXP_RUN1);
        step(5);
        chk("R10 no late fault", EXP_RUN1);
    endtask

    task automatic t_lo_loss();
        bring_up();
        hi_good = 1'b0;
        lo_good = 1'b0;
        #1;
        chk("R1 low loss from normal", EXP_OFF);
        hi_good = 1'b1;
        step(3);
        chk("R1 stays unpowered", EXP_OFF);
        lo_good = 1'b1;
        step(LS - 1);
        chk("R2 restart hold", EXP_OFF);
        step(1);
        chk("R2 restart normal", EXP_RUN1);
    endtask

    task automatic t_params();
        checks++;
        if (!(FLT < HSB)) begin
            fails++;
            $display("FAIL R11: fault delay %0d expected below blanking %0d", FLT, HSB);
        end
    endtask

    initial begin
        t_params();
        t_reset();
        t_hs_absent();
        t_late_high();
        t_high_first();
        t_glitch_and_recover();
        t_collision();
        t_lo_loss();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not end, got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule